// File: doc/BRIEF.md
# Margin-Verified EPROM Programming Sequencer

This block sits on the programmer side of a byte-wide EPROM and writes a whole memory image into it. After a start pulse it walks the image from address zero up to a last address given on a port. Each step is a command to a separate byte cycle engine, which owns the supply rails and the pin timing. The sequencer only decides which command comes next and what to do with the byte the engine reads back.

A run first reads the device and refuses to go on if the image would need any bit to change from 0 to 1. This blank check can be removed with a parameter. The sequencer then requests the programming supply levels and turns on margin mode. Each byte gets fixed-width program pulses, each followed by a verify read, until the read-back equals the image byte. A byte that has verified gets no further pulses. A byte that is still wrong after the pulse limit ends the run as a failure. After the last byte, margin mode is turned off and the whole array is read back twice: first with the core supply at its upper check level, then at its lower check level.

The result is held until the next start: a done flag, a fail flag, the failing address and the phase in which it failed. A strobe reports how many pulses each byte needed.

Top module: `epm_prog_seq`

## Requirements
- R1: After reset `cmd_req`, `done`, `fail` and `pc_valid` are 0, `fail_phase` is 0 and `busy` is 0.
- R2: Once raised, `cmd_req` stays high with `cmd_op`, `cmd_addr` and `cmd_lvl` unchanged until a cycle in which `cmd_ack` is high. In the cycle after that acknowledge, `cmd_req` is low. `cmd_rdata` is taken in the acknowledge cycle.
- R3: The command codes on `cmd_op` are 0 supply select, 1 margin on, 2 margin off, 3 program pulse and 4 read. With the blank check enabled, a run starts by reading addresses 0 to `last_addr` in order. If a read byte has a 0 where the image byte has a 1, the run ends with fail phase 1 at that address. After the blank check (or at once, if it is disabled) the block issues a supply select with level code 0 (programming levels) and then a margin-on command.
- R4: For each address in ascending order the block issues a program pulse carrying the image byte, then a read. The byte passes only if the read-back equals the image byte exactly.
- R5: A byte whose verify fails gets another pulse and another verify. If the verify after pulse number `MAX_PULSES` (25 by default) still fails, the run ends with fail phase 2 at that address, and no further command is issued. A byte may therefore receive at most `MAX_PULSES` pulses.
- R6: Once a byte passes, no further pulse is issued for it. For one cycle `pc_valid` is high, with `pc_addr` set to that byte's address and `pc_count` set to the number of pulses it received.
- R7: After the last address passes, the block issues margin-off. It then issues supply select level 1 (upper core check level) and reads addresses 0 to `last_addr`, then supply select level 2 (lower core check level) and reads them all again. `cmd_lvl` is 0 on every command other than supply select.
- R8: A check read that differs from the image ends the run with fail phase 3 (upper level) or 4 (lower level) at that address. Any fail sets both `done` and `fail`.
- R9: `done`, `fail`, `fail_addr` and `fail_phase` hold until the next start. No command is issued while idle. A start pulse during a run has no effect on the command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request, taken only while idle |
| last_addr | input | AW | Highest image address to program |
| img_addr | output | AW | Address of the image byte needed |
| img_data | input | DW | Image byte at `img_addr`, same cycle |
| cmd_req | output | 1 | Command request to the byte cycle engine |
| cmd_op | output | 3 | Command code (R3) |
| cmd_lvl | output | 2 | Supply level code for supply select |
| cmd_addr | output | AW | Target address of the command |
| cmd_wdata | output | DW | Byte to program |
| cmd_ack | input | 1 | Engine acknowledge, one cycle |
| cmd_rdata | input | DW | Read-back byte, valid with `cmd_ack` on a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (pass or fail) |
| fail | output | 1 | Run failed |
| fail_addr | output | AW | Address where the run failed |
| fail_phase | output | 3 | 0 none, 1 blank, 2 program, 3 upper check, 4 lower check |
| pc_valid | output | 1 | Pulse-count report strobe |
| pc_addr | output | AW | Address of the reported byte |
| pc_count | output | $clog2(MAX_PULSES+1) | Pulses that byte received |

## Verification
An acknowledge taken at a clock edge moves the sequencer on at that same edge. The next request appears one cycle later, after the mandatory gap cycle. `pc_valid` and the final `done`/`fail` values are registered at the edge that accepts the deciding read, so the bench samples every output on the falling edge that follows. The bench's engine model logs every command at the falling edge on which it acknowledges it. That log is compared entry by entry with a sequence the bench builds from the requirements and the model's pulses-needed table. Handshake rules are checked on each falling edge by comparing the current request fields with those of the previous cycle.

// File: rtl/epm_prog_seq.sv
module epm_prog_seq #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int MAX_PULSES  = 25,
  parameter bit BLANK_CHECK = 1'b1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [AW-1:0]                      last_addr,
  output logic [AW-1:0]                      img_addr,
  input  logic [DW-1:0]                      img_data,
  output logic                               cmd_req,
  output logic [2:0]                         cmd_op,
  output logic [1:0]                         cmd_lvl,
  output logic [AW-1:0]                      cmd_addr,
  output logic [DW-1:0]                      cmd_wdata,
  input  logic                               cmd_ack,
  input  logic [DW-1:0]                      cmd_rdata,
  output logic                               busy,
  output logic                               done,
  output logic                               fail,
  output logic [AW-1:0]                      fail_addr,
  output logic [2:0]                         fail_phase,
  output logic                               pc_valid,
  output logic [AW-1:0]                      pc_addr,
  output logic [$clog2(MAX_PULSES+1)-1:0]    pc_count
);
  localparam int NW = $clog2(MAX_PULSES + 1);
  localparam logic [NW-1:0] N_LAST = NW'(MAX_PULSES - 1);

  localparam logic [2:0] OP_SUPPLY = 3'd0;
  localparam logic [2:0] OP_MARGIN_ON = 3'd1;
  localparam logic [2:0] OP_MARGIN_OFF = 3'd2;
  localparam logic [2:0] OP_PULSE = 3'd3;
  localparam logic [2:0] OP_READ = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BLANK, ST_PSUP, ST_MON, ST_PULSE,
    ST_VER, ST_MOFF, ST_CSUP, ST_CHK
  } st_t;

  st_t            st;
  logic           gap, rnd;
  logic [AW-1:0]  addr;
  logic [NW-1:0]  n;

  logic hit, at_last, match, blank_ok, stop;
  logic [2:0] stop_ph;

  assign hit      = cmd_req & cmd_ack;
  assign at_last  = (addr == last_addr);
  assign match    = (cmd_rdata == img_data);
  assign blank_ok = ((~cmd_rdata & img_data) == '0);

  assign stop = hit & ((st == ST_BLANK && !blank_ok) ||
                       (st == ST_VER && !match && n == N_LAST) ||
                       (st == ST_CHK && !match));
  assign stop_ph = (st == ST_BLANK) ? 3'd1 :
                   (st == ST_VER)   ? 3'd2 :
                   rnd              ? 3'd4 : 3'd3;

  assign busy      = (st != ST_IDLE);
  assign cmd_req   = busy & ~gap;
  assign img_addr  = addr;
  assign cmd_addr  = addr;
  assign cmd_wdata = img_data;

  always_comb begin
    cmd_op  = OP_READ;
    cmd_lvl = 2'd0;
    case (st)
      ST_PSUP:  cmd_op = OP_SUPPLY;
      ST_CSUP:  begin cmd_op = OP_SUPPLY; cmd_lvl = rnd ? 2'd2 : 2'd1; end
      ST_MON:   cmd_op = OP_MARGIN_ON;
      ST_MOFF:  cmd_op = OP_MARGIN_OFF;
      ST_PULSE: cmd_op = OP_PULSE;
      default:  cmd_op = OP_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; gap <= 1'b0; rnd <= 1'b0; addr <= '0; n <= '0;
      done <= 1'b0; fail <= 1'b0; fail_addr <= '0; fail_phase <= 3'd0;
      pc_valid <= 1'b0; pc_addr <= '0; pc_count <= '0;
    end else begin
      gap      <= hit;
      pc_valid <= 1'b0;
      if (stop) begin
        st <= ST_IDLE; done <= 1'b1; fail <= 1'b1;
        fail_addr <= addr; fail_phase <= stop_ph;
      end else begin
        case (st)
          ST_IDLE: if (start) begin
            done <= 1'b0; fail <= 1'b0; fail_addr <= '0; fail_phase <= 3'd0;
            addr <= '0; n <= '0; rnd <= 1'b0;
            st <= BLANK_CHECK ? ST_BLANK : ST_PSUP;
          end
          ST_BLANK: if (hit) begin
            if (at_last) begin addr <= '0; st <= ST_PSUP; end
            else addr <= addr + 1'b1;
          end
          ST_PSUP:  if (hit) st <= ST_MON;
          ST_MON:   if (hit) st <= ST_PULSE;
          ST_PULSE: if (hit) st <= ST_VER;
          ST_VER: if (hit) begin
            if (match) begin
              pc_valid <= 1'b1; pc_addr <= addr; pc_count <= n + 1'b1; n <= '0;
              if (at_last) begin addr <= '0; st <= ST_MOFF; end
              else begin addr <= addr + 1'b1; st <= ST_PULSE; end
            end else begin
              n <= n + 1'b1; st <= ST_PULSE;
            end
          end
          ST_MOFF: if (hit) st <= ST_CSUP;
          ST_CSUP: if (hit) st <= ST_CHK;
          ST_CHK: if (hit) begin
            if (at_last) begin
              addr <= '0;
              if (rnd) begin st <= ST_IDLE; done <= 1'b1; end
              else begin rnd <= 1'b1; st <= ST_CSUP; end
            end else addr <= addr + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/epm_prog_seq_chk.sv
module epm_prog_seq_chk #(
  parameter int AW         = 16,
  parameter int MAX_PULSES = 25
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cmd_req,
  input logic                            cmd_ack,
  input logic [2:0]                      cmd_op,
  input logic [1:0]                      cmd_lvl,
  input logic [AW-1:0]                   cmd_addr,
  input logic                            done,
  input logic                            fail,
  input logic [2:0]                      fail_phase,
  input logic                            pc_valid,
  input logic [$clog2(MAX_PULSES+1)-1:0] pc_count
);
  logic [AW-1:0] last_pulse_addr;
  logic          pulse_seen;
  int unsigned   pulse_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pulse_addr <= '0; pulse_seen <= 1'b0; pulse_run <= 0;
    end else if (pc_valid || done) begin
      pulse_seen <= 1'b0; pulse_run <= 0;
    end else if (cmd_req && cmd_ack && cmd_op == 3'd3) begin
      pulse_run       <= (pulse_seen && cmd_addr == last_pulse_addr) ? pulse_run + 1 : 1;
      last_pulse_addr <= cmd_addr;
      pulse_seen      <= 1'b1;
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_lvl));

  assert_req_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_ack |=> !cmd_req);

  assert_pulse_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_run <= MAX_PULSES);

  assert_pc_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> (pc_count != 0) && (int'(pc_count) <= MAX_PULSES));

  assert_lvl_only_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_op != 3'd0 |-> cmd_lvl == 2'd0);

  assert_fail_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done && fail_phase != 3'd0);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_req);
endmodule

bind epm_prog_seq epm_prog_seq_chk #(.AW(AW), .MAX_PULSES(MAX_PULSES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_op(cmd_op),
  .cmd_lvl(cmd_lvl), .cmd_addr(cmd_addr), .done(done), .fail(fail),
  .fail_phase(fail_phase), .pc_valid(pc_valid), .pc_count(pc_count)
);

// File: tb/epm_prog_seq_tb_top.sv
module epm_prog_seq_tb_top;
  localparam int AW = 16, DW = 8, MAXP = 25, NW = $clog2(MAXP + 1);
  localparam int OP_SUP = 0, OP_MON = 1, OP_MOFF = 2, OP_PULSE = 3, OP_READ = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] last_addr = '0, img_addr, cmd_addr, fail_addr, pc_addr;
  logic [DW-1:0] img_data, cmd_wdata, cmd_rdata = '0;
  logic cmd_req, cmd_ack = 1'b0, busy, done, fail, pc_valid;
  logic [2:0] cmd_op, fail_phase;
  logic [1:0] cmd_lvl;
  logic [NW-1:0] pc_count;

  always #5 clk = ~clk;

  epm_prog_seq #(.AW(AW), .DW(DW), .MAX_PULSES(MAXP), .BLANK_CHECK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .last_addr(last_addr),
    .img_addr(img_addr), .img_data(img_data), .cmd_req(cmd_req), .cmd_op(cmd_op),
    .cmd_lvl(cmd_lvl), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
    .cmd_rdata(cmd_rdata), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_phase(fail_phase), .pc_valid(pc_valid), .pc_addr(pc_addr), .pc_count(pc_count));

  logic [DW-1:0] image [16];
  logic [DW-1:0] mem [16];
  int need [16], pulses [16], pc_log [16];
  int fault_lvl, fault_addr, cur_lvl, ack_delay, wait_cnt;
  int log_op [4096], log_addr [4096], log_lvl [4096], nlog;
  int e_op [4096], e_addr [4096], e_lvl [4096], nexp;
  int hs_err, checks = 0, errors = 0;
  bit finished = 0;

  assign img_data = image[img_addr[3:0]];

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // engine model: acknowledges at a falling edge, logs the command
  initial forever begin
    @(negedge clk);
    if (cmd_ack) begin cmd_ack = 1'b0; wait_cnt = 0; end
    else if (cmd_req) begin
      if (wait_cnt < ack_delay) wait_cnt++;
      else begin
        int a;
        a = int'(cmd_addr[3:0]);
        log_op[nlog] = int'(cmd_op); log_addr[nlog] = int'(cmd_addr); log_lvl[nlog] = int'(cmd_lvl);
        if (nlog < 4095) nlog++;
        case (int'(cmd_op))
          OP_SUP: cur_lvl = int'(cmd_lvl);
          OP_PULSE: begin
            pulses[a]++;
            if (pulses[a] >= need[a]) mem[a] = mem[a] & cmd_wdata;
          end
          OP_READ: cmd_rdata = (cur_lvl == fault_lvl && a == fault_addr) ? (mem[a] ^ 8'h01) : mem[a];
          default: ;
        endcase
        cmd_ack = 1'b1; wait_cnt = 0;
      end
    end
  end

  // handshake monitor and pulse-count capture
  logic p_req = 0, p_ack = 0; logic [2:0] p_op = '0; logic [AW-1:0] p_addr = '0; logic [1:0] p_lvl = '0;
  initial forever begin
    @(negedge clk);
    #1;
    if (p_req && !p_ack && (!cmd_req || cmd_op != p_op || cmd_addr != p_addr || cmd_lvl != p_lvl)) hs_err++;
    if (p_req && p_ack && cmd_req) hs_err++;
    if (pc_valid) pc_log[pc_addr[3:0]] = int'(pc_count);
    p_req = cmd_req; p_ack = cmd_ack; p_op = cmd_op; p_addr = cmd_addr; p_lvl = cmd_lvl;
  end

  task automatic init_model(input int last);
    for (int i = 0; i < 16; i++) begin
      image[i] = 8'(8'h5A ^ (i * 37)); mem[i] = 8'hFF; need[i] = 1; pulses[i] = 0; pc_log[i] = 0;
    end
    fault_lvl = -1; fault_addr = -1; cur_lvl = 0; nlog = 0; nexp = 0; hs_err = 0;
    last_addr = AW'(last);
  endtask

  task automatic push(input int op, input int a, input int l);
    e_op[nexp] = op; e_addr[nexp] = a; e_lvl[nexp] = l; nexp++;
  endtask

  task automatic build_exp(input int last, input int stop_ph, input int stop_a);
    for (int a = 0; a <= last; a++) begin
      push(OP_READ, a, 0);
      if (stop_ph == 1 && a == stop_a) return;
    end
    push(OP_SUP, 0, 0); push(OP_MON, 0, 0);
    for (int a = 0; a <= last; a++) begin
      int k;
      k = (need[a] > MAXP) ? MAXP : need[a];
      for (int j = 0; j < k; j++) begin push(OP_PULSE, a, 0); push(OP_READ, a, 0); end
      if (need[a] > MAXP) return;
    end
    push(OP_MOFF, 0, 0);
    for (int r = 1; r <= 2; r++) begin
      push(OP_SUP, 0, r);
      for (int a = 0; a <= last; a++) begin
        push(OP_READ, a, 0);
        if (stop_ph == r + 2 && a == stop_a) return;
      end
    end
  endtask

  task automatic run(input string rq, input int last, input int efail, input int eph,
                     input int eaddr, input bit inject_start);
    int cyc;
    build_exp(last, eph, eaddr);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (inject_start && cyc == 15) start = 1'b1;
      if (inject_start && cyc == 16) start = 1'b0;
    end
    chk({rq, " run completes (watchdog)"}, int'(cyc < 20000), 1);
    chk({rq, " fail flag R8"}, int'(fail), efail);
    chk({rq, " fail phase"}, int'(fail_phase), eph);
    if (efail != 0) chk({rq, " fail address"}, int'(fail_addr), eaddr);
    chk({rq, " command count"}, nlog, nexp);
    begin
      int bad;
      bad = -1;
      for (int i = 0; i < nexp && i < nlog; i++)
        if (bad < 0 && (log_op[i] != e_op[i] || (log_op[i] != OP_SUP && log_op[i] != OP_MON && log_op[i] != OP_MOFF && log_addr[i] != e_addr[i]) || log_lvl[i] != e_lvl[i])) bad = i;
      chk({rq, " first mismatching command index (R3 R4 R7)"}, bad, -1);
    end
    chk({rq, " handshake violations R2"}, hs_err, 0);
    begin
      int qreq;
      qreq = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (cmd_req || !done) qreq++; end
      chk({rq, " idle hold R9"}, qreq, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 req after reset", int'(cmd_req), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 fail after reset", int'(fail), 0);
    chk("R1 phase after reset", int'(fail_phase), 0);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 pc_valid after reset", int'(pc_valid), 0);
  endtask

  task automatic t_basic;
    init_model(3); ack_delay = 0;
    run("R4 R9 basic", 3, 0, 0, 0, 1'b1);
    for (int a = 0; a <= 3; a++) chk("R6 count basic", pc_log[a], 1);
    for (int a = 0; a <= 3; a++) chk("R4 programmed byte", int'(mem[a]), int'(image[a]));
  endtask

  task automatic t_retry;
    init_model(4); ack_delay = 2;
    need[0] = 3; need[1] = 1; need[2] = MAXP; need[3] = 2; need[4] = 7;
    run("R5 R6 retry", 4, 0, 0, 0, 1'b0);
    for (int a = 0; a <= 4; a++) chk("R6 pulse count report", pc_log[a], need[a]);
    for (int a = 0; a <= 4; a++) chk("R6 no extra pulses", pulses[a], need[a]);
  endtask

  task automatic t_limit;
    init_model(3); ack_delay = 1; need[1] = MAXP + 1;
    run("R5 limit", 3, 1, 2, 1, 1'b0);
    chk("R5 pulses at limit", pulses[1], MAXP);
    chk("R5 no pulse past fail", pulses[2], 0);
  endtask

  task automatic t_blank;
    init_model(3); ack_delay = 0;
    mem[1] = 8'h7F; image[1] = 8'h3C;
    mem[2] = 8'hF0; image[2] = 8'h0F;
    run("R3 blank", 3, 1, 1, 2, 1'b0);
    chk("R3 no pulses after blank fail", pulses[0], 0);
  endtask

  task automatic t_blank_ok;
    init_model(2); ack_delay = 0;
    mem[1] = 8'h7F; image[1] = 8'h3C;
    run("R3 partly written", 2, 0, 0, 0, 1'b0);
    chk("R3 partly written byte", int'(mem[1]), 8'h3C);
  endtask

  task automatic t_check_hi;
    init_model(3); ack_delay = 0; fault_lvl = 1; fault_addr = 2;
    run("R8 upper check", 3, 1, 3, 2, 1'b0);
  endtask

  task automatic t_check_lo;
    init_model(3); ack_delay = 0; fault_lvl = 2; fault_addr = 0;
    run("R8 lower check", 3, 1, 4, 0, 1'b0);
  endtask

  task automatic t_single;
    init_model(0); ack_delay = 0; need[0] = 4;
    run("R7 single byte", 0, 0, 0, 0, 1'b0);
    chk("R6 single count", pc_log[0], 4);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    ack_delay = 0; wait_cnt = 0; nlog = 0; fault_lvl = -1; fault_addr = -1;
    for (int i = 0; i < 16; i++) begin image[i] = '0; mem[i] = 8'hFF; need[i] = 1; pulses[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_retry;
    t_limit;
    t_blank;
    t_blank_ok;
    t_check_hi;
    t_check_lo;
    t_single;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule